// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block drives a multichannel analog front end from a 16-bit write port. Software first sets a per-channel gain/range code: it points the multiplexer at one channel and then writes that channel's code. It then writes the scan interval as a first channel and a last channel in one packed word. After that, each qualified conversion trigger starts one conversion on the channel under the scan pointer and moves the pointer one step through the interval. The pointer returns to the first channel after the last one.

Three trigger sources exist: a software strobe (any write to the trigger address), a pacer tick, and the rising edge of an external trigger. A control register enables each source. An optional gate lets pacer ticks through only while an external gate input is high. The converter is reached through a start pulse and a done pulse. Each result comes back tagged with the number of the channel it was taken from, so a consumer can detect a lost sample.

Top module: `asc_scan_seq`

## Requirements
- R1: After reset, `adc_start` and `smp_valid` are 0, `ctrl_out` is 0, and the scan interval and pointer are channel 0.
- R2: A write to address 2 stores `wr_data[5:0]` as the range code of the channel held in the first-channel field. The code of the converted channel is presented on `adc_range` together with `adc_start`.
- R3: Bit 5 of a range code marks a differential channel. On an odd channel this bit is stored as 0, and on an even channel it is stored as written.
- R4: A write to address 0 starts a conversion (`adc_start` high for one cycle after the write edge) only while control bit 0 is set. With the bit clear, the write has no effect.
- R5: With control bit 1 set, a `pacer_tick` cycle starts a conversion. When control bit 3 is also set, ticks count only while `ext_gate` is high.
- R6: With control bit 2 set, a rising edge of `ext_trig` starts one conversion. A level held high gives no further conversions.
- R7: A write to address 4 sets the first channel from `wr_data[3:0]` and the last channel from `wr_data[11:8]`. Conversions visit first, first+1, ..., last and then return to first. Equal fields select a single channel.
- R8: When the first channel is greater than the last, the scan runs up to channel 15, continues from channel 0 up to the last channel, and then returns to the first.
- R9: A write to address 4 moves the scan pointer to the new first channel, whatever its previous position.
- R10: Triggers from any source are ignored from `adc_start` until `adc_done`. At most one conversion is in flight.
- R11: One cycle after `adc_done` of a pending conversion, `smp_valid` pulses with `smp_data[15:12]` = converted channel and `smp_data[11:0]` = `adc_data`.
- R12: A write to address 6 stores `wr_data[6:0]` in the control register, which is visible on `ctrl_out`. Bits 4 to 6 (interrupt enable, interrupt mode, counter clock select) are held for the surrounding logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 trigger, 2 range, 4 interval, 6 control) |
| wr_data | input | 16 | Write data |
| pacer_tick | input | 1 | Internal pacer tick, one cycle per period |
| ext_trig | input | 1 | External trigger level, rising edge used |
| ext_gate | input | 1 | External gate level for pacer ticks |
| adc_done | input | 1 | Converter result valid pulse |
| adc_data | input | 12 | Converter result |
| adc_start | output | 1 | Conversion start pulse |
| adc_ch | output | 4 | Channel for the conversion being started |
| adc_range | output | 6 | Range code for that channel |
| smp_valid | output | 1 | Tagged sample valid pulse |
| smp_data | output | 16 | Channel tag and result |
| ctrl_out | output | 7 | Control register contents |

## Verification
The assertions assume that the converter raises `adc_done` only for a conversion that was started, and only once per start. They also assume that `adc_data` is valid in the `adc_done` cycle. The bench converter model answers each observed start exactly once after a programmable latency, so `adc_done` never arrives while the block is idle. Extra triggers are sent only while a conversion is pending, which tests that they are dropped. The external trigger and the gate are driven at a negative edge, as clean single-clock levels.

// File: rtl/asc_pkg.sv
package asc_pkg;
  typedef enum logic [2:0] {
    SEL_TRIG  = 3'd0,
    SEL_RANGE = 3'd2,
    SEL_MUX   = 3'd4,
    SEL_CTRL  = 3'd6
  } asc_sel_e;

  localparam int CTL_W     = 7;
  localparam int CTL_SW    = 0;
  localparam int CTL_PACER = 1;
  localparam int CTL_EXT   = 2;
  localparam int CTL_GATE  = 3;
  localparam int CTL_IRQ   = 4;
  localparam int CTL_MODE  = 5;
  localparam int CTL_CLK   = 6;

  localparam int DIFF_BIT  = 5;
endpackage

// File: rtl/asc_regs.sv
module asc_regs
  import asc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CH_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [CTL_W-1:0] ctrl_q,
  output logic [CH_W-1:0]  first_q,
  output logic [CH_W-1:0]  last_q,
  output logic             mux_wr,
  output logic             range_wr,
  output logic             sw_strobe
);
  localparam int FIELD_W = DW / 2;

  always_comb begin
    mux_wr    = wr_en && (wr_addr == SEL_MUX);
    range_wr  = wr_en && (wr_addr == SEL_RANGE);
    sw_strobe = wr_en && (wr_addr == SEL_TRIG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      if (wr_en && (wr_addr == SEL_CTRL))
        ctrl_q <= wr_data[CTL_W-1:0];
      if (mux_wr) begin
        first_q <= wr_data[CH_W-1:0];
        last_q  <= wr_data[FIELD_W+CH_W-1:FIELD_W];
      end
    end
  end
endmodule

// File: rtl/asc_range_mem.sv
module asc_range_mem
  import asc_pkg::*;
#(
  parameter int CH_W = 4,
  parameter int RW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CH_W-1:0] waddr,
  input  logic [RW-1:0]   wdata,
  input  logic [CH_W-1:0] raddr,
  output logic [RW-1:0]   rdata
);
  localparam int NCH = 1 << CH_W;

  function automatic logic [RW-1:0] legal_code(input logic [CH_W-1:0] ch,
                                               input logic [RW-1:0] code);
    logic [RW-1:0] c;
    c = code;
    if (ch[0]) c[DIFF_BIT] = 1'b0;
    return c;
  endfunction

  logic [RW-1:0] mem [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we && (waddr == CH_W'(g)))
        mem[g] <= legal_code(CH_W'(g), wdata);
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/asc_scan_ptr.sv
module asc_scan_ptr #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] first,
  input  logic [CH_W-1:0] last,
  input  logic [CH_W-1:0] load_val,
  input  logic            advance,
  output logic [CH_W-1:0] ptr
);
  function automatic logic [CH_W-1:0] step(input logic [CH_W-1:0] cur,
                                           input logic [CH_W-1:0] lo,
                                           input logic [CH_W-1:0] hi);
    return (cur == hi) ? lo : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (load)
      ptr <= load_val;
    else if (advance)
      ptr <= step(ptr, first, last);
  end
endmodule

// File: rtl/asc_trig.sv
module asc_trig
  import asc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctrl,
  input  logic             sw_strobe,
  input  logic             pacer_tick,
  input  logic             ext_trig,
  input  logic             ext_gate,
  input  logic             busy,
  output logic             sw_hit,
  output logic             pacer_hit,
  output logic             ext_hit,
  output logic             fire
);
  logic ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  always_comb begin
    sw_hit    = ctrl[CTL_SW] && sw_strobe;
    pacer_hit = ctrl[CTL_PACER] && pacer_tick && (!ctrl[CTL_GATE] || ext_gate);
    ext_hit   = ctrl[CTL_EXT] && ext_trig && !ext_q;
    fire      = !busy && (sw_hit || pacer_hit || ext_hit);
  end
endmodule

// File: rtl/asc_scan_seq.sv
module asc_scan_seq
  import asc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CH_W = 4,
  parameter int SW   = 12,
  parameter int RW   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             pacer_tick,
  input  logic             ext_trig,
  input  logic             ext_gate,
  input  logic             adc_done,
  input  logic [SW-1:0]    adc_data,
  output logic             adc_start,
  output logic [CH_W-1:0]  adc_ch,
  output logic [RW-1:0]    adc_range,
  output logic             smp_valid,
  output logic [DW-1:0]    smp_data,
  output logic [CTL_W-1:0] ctrl_out
);
  function automatic logic [DW-1:0] tag(input logic [CH_W-1:0] ch,
                                        input logic [SW-1:0] v);
    return {ch, v};
  endfunction

  logic [CH_W-1:0] first_q, last_q, ptr;
  logic            mux_wr, range_wr, sw_strobe;
  logic [RW-1:0]   rng_rd;
  logic            busy, fire, complete;
  logic            sw_hit, pacer_hit, ext_hit;
  logic [CH_W-1:0] conv_ch;
  logic [RW-1:0]   conv_rng;

  asc_regs #(.DW(DW), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_out), .first_q(first_q),
    .last_q(last_q), .mux_wr(mux_wr), .range_wr(range_wr),
    .sw_strobe(sw_strobe)
  );

  asc_range_mem #(.CH_W(CH_W), .RW(RW)) u_rng (
    .clk(clk), .rst_n(rst_n), .we(range_wr), .waddr(first_q),
    .wdata(wr_data[RW-1:0]), .raddr(ptr), .rdata(rng_rd)
  );

  asc_scan_ptr #(.CH_W(CH_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(mux_wr), .first(first_q),
    .last(last_q), .load_val(wr_data[CH_W-1:0]), .advance(fire), .ptr(ptr)
  );

  asc_trig u_trig (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_out), .sw_strobe(sw_strobe),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig), .ext_gate(ext_gate),
    .busy(busy), .sw_hit(sw_hit), .pacer_hit(pacer_hit),
    .ext_hit(ext_hit), .fire(fire)
  );

  assign complete = busy && adc_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      adc_start <= 1'b0;
      conv_ch   <= '0;
      conv_rng  <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      adc_start <= fire;
      smp_valid <= complete;
      if (fire) begin
        busy     <= 1'b1;
        conv_ch  <= ptr;
        conv_rng <= rng_rd;
      end else if (complete) begin
        busy <= 1'b0;
      end
      if (complete)
        smp_data <= tag(conv_ch, adc_data);
    end
  end

  assign adc_ch    = conv_ch;
  assign adc_range = conv_rng;
endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
  parameter int DW   = 16,
  parameter int CH_W = 4,
  parameter int RW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            adc_start,
  input logic            adc_done,
  input logic [CH_W-1:0] adc_ch,
  input logic [RW-1:0]   adc_range,
  input logic            smp_valid,
  input logic [DW-1:0]   smp_data,
  input logic [CH_W-1:0] ptr,
  input logic [CH_W-1:0] first_q,
  input logic [CH_W-1:0] last_q
);
  // R10: nothing starts while a conversion is pending
  a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adc_done) |=> !adc_start);

  // R10: start is a single-cycle pulse
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R11: completion yields a sample tagged with the converted channel
  a_r11_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adc_done) |=> (smp_valid && smp_data[DW-1:DW-CH_W] == $past(adc_ch)));

  // R11: no sample without a completion
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || !adc_done) |=> !smp_valid);

  // R3: odd channels never present the differential flag
  a_r3_diff_even: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && adc_ch[0]) |-> !adc_range[5]);

  // R7, R8: pointer stays inside the (possibly wrapping) interval
  a_r7_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q <= last_q) ? (ptr >= first_q && ptr <= last_q)
                        : (ptr >= first_q || ptr <= last_q));
endmodule

bind asc_scan_seq asc_checker #(.DW(DW), .CH_W(CH_W), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .adc_start(adc_start),
  .adc_done(adc_done), .adc_ch(adc_ch), .adc_range(adc_range),
  .smp_valid(smp_valid), .smp_data(smp_data), .ptr(ptr),
  .first_q(first_q), .last_q(last_q)
);

// File: tb/tb_asc_scan_seq.sv
`timescale 1ns/1ps
module tb_asc_scan_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        pacer_tick, ext_trig, ext_gate;
  logic        adc_done;
  logic [11:0] adc_data;
  logic        adc_start;
  logic [3:0]  adc_ch;
  logic [5:0]  adc_range;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic [6:0]  ctrl_out;

  always #4 clk = ~clk;

  asc_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pacer_tick(pacer_tick), .ext_trig(ext_trig),
    .ext_gate(ext_gate), .adc_done(adc_done), .adc_data(adc_data),
    .adc_start(adc_start), .adc_ch(adc_ch), .adc_range(adc_range),
    .smp_valid(smp_valid), .smp_data(smp_data), .ctrl_out(ctrl_out)
  );

  int checks = 0, fails = 0;
  int adc_lat = 3;
  int n_st = 0, n_pulse = 0, n_smp = 0;
  logic [3:0]  st_ch  [256];
  logic [5:0]  st_rng [256];
  logic [11:0] st_dat [256];
  logic [15:0] smp_log[256];
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // converter model: answers each observed start once
  initial begin
    adc_done = 1'b0;
    adc_data = '0;
    forever begin
      @(negedge clk);
      if (adc_start === 1'b1) begin
        logic [11:0] d;
        st_ch[n_st]  = adc_ch;
        st_rng[n_st] = adc_range;
        d = 12'(n_st * 37 + 5 + int'(adc_ch));
        st_dat[n_st] = d;
        n_st++;
        repeat (adc_lat - 1) @(negedge clk);
        adc_done = 1'b1;
        adc_data = d;
        @(negedge clk);
        adc_done = 1'b0;
        if (adc_start === 1'b1) n_pulse++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (adc_start === 1'b1) n_pulse++;
    if (smp_valid === 1'b1) begin
      smp_log[n_smp] = smp_data;
      n_smp++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_smp(input int target);
    for (int i = 0; i < 200 && n_smp < target; i++) @(negedge clk);
  endtask

  // one software conversion; checks channel order and tag
  task automatic sw_conv(input logic [3:0] exp_ch, input string req);
    int k;
    k = n_smp;
    wr(3'd0, 16'h0);
    wait_smp(k + 1);
    chk(n_smp == k + 1, req, n_smp, k + 1);
    chk(st_ch[k] == exp_ch, req, st_ch[k], exp_ch);
    chk(smp_log[k] == {st_ch[k], st_dat[k]}, "R11", smp_log[k], {st_ch[k], st_dat[k]});
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(adc_start == 1'b0, "R1", adc_start, 0);
    chk(smp_valid == 1'b0, "R1", smp_valid, 0);
    chk(ctrl_out == 7'h00, "R1", ctrl_out, 0);
  endtask

  task automatic t_ctrl;
    int p;
    wr(3'd6, 16'h0070);
    chk(ctrl_out == 7'h70, "R12", ctrl_out, 7'h70);
    p = n_pulse;
    wr(3'd0, 16'h0);
    repeat (8) @(negedge clk);
    chk(n_pulse == p, "R4 disabled sw", n_pulse - p, 0);
    wr(3'd6, 16'h0001);
    chk(ctrl_out == 7'h01, "R12", ctrl_out, 1);
    // R1: pointer at channel 0 after reset
    sw_conv(4'd0, "R1");
  endtask

  task automatic t_range;
    logic [5:0] code [4] = '{6'h21, 6'h22, 6'h03, 6'h24};
    logic [5:0] exp  [4] = '{6'h21, 6'h02, 6'h03, 6'h04};
    int k;
    for (int c = 0; c < 4; c++) begin
      wr(3'd4, {4'h0, 4'(c), 4'h0, 4'(c)});
      wr(3'd2, {10'h0, code[c]});
    end
    wr(3'd4, 16'h0300);
    k = n_st;
    for (int c = 0; c < 4; c++) sw_conv(4'(c), "R7");
    for (int c = 0; c < 4; c++)
      chk(st_rng[k + c] == exp[c], (c % 2) ? "R3" : "R2", st_rng[k + c], exp[c]);
    sw_conv(4'd0, "R7 wrap");
  endtask

  task automatic t_single;
    wr(3'd4, 16'h0505);
    for (int i = 0; i < 3; i++) sw_conv(4'd5, "R7 single");
  endtask

  task automatic t_wrap;
    logic [3:0] seq [5] = '{4'd14, 4'd15, 4'd0, 4'd1, 4'd14};
    wr(3'd4, 16'h010E);
    for (int i = 0; i < 5; i++) sw_conv(seq[i], "R8");
  endtask

  task automatic t_reload;
    wr(3'd4, 16'h0602);
    sw_conv(4'd2, "R9");
    sw_conv(4'd3, "R9");
    wr(3'd4, 16'h0602);
    sw_conv(4'd2, "R9 reload");
  endtask

  task automatic t_busy;
    int p, k;
    adc_lat = 10;
    wr(3'd6, 16'h0003);
    wr(3'd4, 16'h0F00);
    p = n_pulse; k = n_smp;
    wr(3'd0, 16'h0);
    @(negedge clk);
    wr(3'd0, 16'h0);
    pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
    wait_smp(k + 1);
    repeat (4) @(negedge clk);
    chk(n_pulse - p == 1, "R10", n_pulse - p, 1);
    chk(n_smp - k == 1, "R10", n_smp - k, 1);
    adc_lat = 3;
  endtask

  task automatic t_pacer;
    int p;
    wr(3'd6, 16'h0002);
    p = n_pulse;
    pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
    repeat (8) @(negedge clk);
    chk(n_pulse - p == 1, "R5", n_pulse - p, 1);
    wr(3'd6, 16'h000A);
    ext_gate = 1'b0; p = n_pulse;
    pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
    repeat (8) @(negedge clk);
    chk(n_pulse == p, "R5 gate low", n_pulse - p, 0);
    ext_gate = 1'b1;
    pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
    repeat (8) @(negedge clk);
    chk(n_pulse - p == 1, "R5 gate high", n_pulse - p, 1);
    ext_gate = 1'b0;
  endtask

  task automatic t_ext;
    int p;
    wr(3'd6, 16'h0001);
    p = n_pulse;
    ext_trig = 1'b1; repeat (10) @(negedge clk); ext_trig = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_pulse == p, "R6 disabled", n_pulse - p, 0);
    wr(3'd6, 16'h0004);
    ext_trig = 1'b1; repeat (20) @(negedge clk); ext_trig = 1'b0;
    repeat (6) @(negedge clk);
    chk(n_pulse - p == 1, "R6 edge", n_pulse - p, 1);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    pacer_tick = 1'b0; ext_trig = 1'b0; ext_gate = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ctrl;
    t_range;
    t_single;
    t_wrap;
    t_reload;
    t_busy;
    t_pacer;
    t_ext;
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule